// File: doc/BRIEF.md
# Sleep Entry and Wake-Source Controller

This block is the power-management register unit that carries a system into sleep and back out. Software writes a sleep request into a control register. The block then runs a power-down handshake with the memory controller and asserts a sleep-request output once memory reports that it is down. The request bit stays set while the system sleeps, so software can poll it and see it drop when the system wakes.

Thirty-two raw wake-trigger inputs are armed through an enable register. Each input passes through a two-flop synchronizer and a rising-edge detector. An armed rising edge sets a bit in a reason latch. The reason bit stays set after the input falls, and it is cleared only when software writes 1 to it. The wake interrupt is the OR of all reason bits. While the system sleeps, any set reason bit starts the wake sequence. The memory power-down request is released, and the powered-down status clears once memory reports that it is back up.

All pins are plain control and status wires. The register bus takes a single-cycle write strobe with byte enables and has a combinational read port. It has no back-pressure.

Top module: `pwr_sleep_wake`

## Requirements
- R1: After reset, all three registers read 0, and `sleep_req`, `mem_pd_req` and `wake_irq` are 0.
- R2: The enable register at byte offset 0x4 is read/write. A write changes only the bytes whose `bus_be` bit is 1, where `bus_be[i]` covers data bits 8i+7..8i.
- R3: A reason bit (reason register at offset 0x8, same bit positions as the enable register) is set by a rising edge of the matching `wake_raw` bit only while that enable bit is 1. The bit becomes visible after the third rising clock edge following the input change. An edge on a disabled input sets nothing.
- R4: A set reason bit stays set when its input falls or stays high, until it is acknowledged.
- R5: Writing 1 to a reason bit in an enabled byte clears it. Writing 0, or writing through a byte whose enable is 0, leaves the bit unchanged.
- R6: If a new armed edge and an acknowledge write for the same bit fall in the same cycle, the bit stays set.
- R7: `wake_irq` is 1 exactly when at least one reason bit is 1.
- R8: Writing 1 to control bit 0 (offset 0x0, byte 0 enabled) while the block is idle asserts `mem_pd_req` after that clock edge. Control bit 0 then reads 1.
- R9: After `mem_pd_ack` is seen high during power-down, `sleep_req` rises at the next edge and control bit 15 (memory powered down) reads 1.
- R10: While asleep, a nonzero reason register drops `sleep_req`, `mem_pd_req` and control bit 0 at the next edge. Bit 15 stays 1 until `mem_pd_ack` is seen low, after which the block returns to idle.
- R11: Control bits 1 to 14 and 16 to 31 read 0, and writes to bit 15 have no effect.
- R12: Writing 0 to control bit 0 while a sleep request is in progress does not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wake_raw | input | 32 | Asynchronous raw wake-trigger inputs |
| mem_pd_ack | input | 1 | Memory reports powered down (1) or up (0) |
| mem_pd_req | output | 1 | Request to power memory down |
| sleep_req | output | 1 | System sleep request |
| wake_irq | output | 1 | Wake interrupt, OR of reason bits |

## Verification
On every cycle, the assertions check how the reason latch updates: new bits appear only where an armed edge occurred, unacknowledged bits are held, acknowledged bits clear, and an edge coinciding with an acknowledge wins. They also check that the sequencer never requests sleep without holding memory down, that it leaves sleep the cycle after a reason is pending, and that it starts power-down only in response to a request. Only the bench scenarios show the values software sees: the three-cycle latency through the synchronizer, byte-enable masking, the read-only and zero bits of the control register, and a full sleep, wake and power-up round trip under a realistic acknowledge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_ENABLE = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_REASON = 4'h8;

  localparam int unsigned CTRL_REQ_BIT  = 0;
  localparam int unsigned CTRL_DOWN_BIT = 15;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_PWR_DN = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_PWR_UP = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_trig_sync.sv
module pwr_trig_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;

  // R3: an edge pulse lasts one cycle unless the line toggles again
  a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/pwr_wake_bank.sv
module pwr_wake_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic [W-1:0] en_bmask,
  input  logic [W-1:0] en_wdata,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] ack_mask,
  output logic [W-1:0] enable_q,
  output logic [W-1:0] reason_q
);
  logic [W-1:0] set_mask;

  assign set_mask = rise & enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      reason_q <= '0;
    end else begin
      if (en_we) enable_q <= (enable_q & ~en_bmask) | (en_wdata & en_bmask);
      reason_q <= (reason_q & ~ack_mask) | set_mask;
    end
  end

  // R3: a new reason bit needs an armed edge the cycle before
  a_r3_set_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((reason_q & ~$past(reason_q) & ~$past(rise & enable_q)) == '0));
  // R4: unacknowledged bits are held
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(reason_q) & ~$past(ack_mask) & ~reason_q) == '0));
  // R5: acknowledged bits without a new edge clear
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_mask != '0) |=> ((reason_q & $past(ack_mask) & ~$past(rise & enable_q)) == '0));
  // R6: edge beats acknowledge
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & enable_q & ack_mask) != '0) |=>
      ((reason_q & $past(rise & enable_q & ack_mask)) == $past(rise & enable_q & ack_mask)));
endmodule

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq
  import pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_pulse,
  input  logic wake_pending,
  input  logic mem_pd_ack,
  output logic mem_pd_req,
  output logic sleep_req,
  output logic req_pending,
  output logic mem_down
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:   if (req_pulse)    state_d = PS_PWR_DN;
      PS_PWR_DN: if (mem_pd_ack)   state_d = PS_SLEEP;
      PS_SLEEP:  if (wake_pending) state_d = PS_PWR_UP;
      PS_PWR_UP: if (!mem_pd_ack)  state_d = PS_IDLE;
      default:                     state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  assign mem_pd_req  = (state_q == PS_PWR_DN) || (state_q == PS_SLEEP);
  assign sleep_req   = (state_q == PS_SLEEP);
  assign req_pending = (state_q == PS_PWR_DN) || (state_q == PS_SLEEP);
  assign mem_down    = (state_q == PS_SLEEP) || (state_q == PS_PWR_UP);

  // R9: sleep only while memory is held powered down
  a_r9_sleep_holds_pd: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (mem_pd_req && mem_down));
  // R10: a pending wake leaves sleep at the next edge
  a_r10_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && wake_pending) |=> (!sleep_req && !mem_pd_req));
  // R8: power-down starts only from a software request
  a_r8_pd_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pd_req) |-> $past(req_pulse));
endmodule

// File: rtl/pwr_sleep_wake.sv
module pwr_sleep_wake
  import pwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] wake_raw,
  input  logic              mem_pd_ack,
  output logic              mem_pd_req,
  output logic              sleep_req,
  output logic              wake_irq
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] reason_q;
  logic [DATA_W-1:0] ack_mask;
  logic              wr_ctrl, wr_en, wr_rsn;
  logic              req_pulse, req_pending, mem_down;

  for (genvar b = 0; b < BE_W; b++) begin : g_bmask
    assign bmask[8*b +: 8] = {8{bus_be[b]}};
  end

  assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_en     = bus_wr && (bus_addr == OFF_ENABLE);
  assign wr_rsn    = bus_wr && (bus_addr == OFF_REASON);
  assign req_pulse = wr_ctrl && bus_be[0] && bus_wdata[CTRL_REQ_BIT];
  assign ack_mask  = wr_rsn ? (bus_wdata & bmask) : '0;

  pwr_trig_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (wake_raw),
    .rise (rise)
  );

  pwr_wake_bank #(.W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_we   (wr_en),
    .en_bmask(bmask),
    .en_wdata(bus_wdata),
    .rise    (rise),
    .ack_mask(ack_mask),
    .enable_q(enable_q),
    .reason_q(reason_q)
  );

  pwr_sleep_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_pulse   (req_pulse),
    .wake_pending(wake_irq),
    .mem_pd_ack  (mem_pd_ack),
    .mem_pd_req  (mem_pd_req),
    .sleep_req   (sleep_req),
    .req_pending (req_pending),
    .mem_down    (mem_down)
  );

  assign wake_irq = |reason_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_CTRL: begin
        bus_rdata[CTRL_REQ_BIT]  = req_pending;
        bus_rdata[CTRL_DOWN_BIT] = mem_down;
      end
      OFF_ENABLE: bus_rdata = enable_q;
      OFF_REASON: bus_rdata = reason_q;
      default:    bus_rdata = '0;
    endcase
  end

  // R7: interrupt tracks the reason latch
  a_r7_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    (reason_q == '0) |-> !wake_irq);
  // R12: a pending request is not withdrawn by a bus write
  a_r12_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_pending) && !$past(sleep_req) && !$past(mem_pd_ack)) |-> req_pending);
endmodule

// File: tb/pwr_sleep_wake_bench.sv
module pwr_sleep_wake_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_rdata;
  logic [31:0] wake_raw = '0;
  logic        mem_pd_ack = 1'b0;
  logic        mem_pd_req, sleep_req, wake_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_wake u_pwr_sleep_wake (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .wake_raw(wake_raw), .mem_pd_ack(mem_pd_ack), .mem_pd_req(mem_pd_req),
    .sleep_req(sleep_req), .wake_irq(wake_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // raise bits at a negedge, return at the negedge after the third posedge
  task automatic raise(input logic [31:0] bits);
    @(negedge clk);
    wake_raw = wake_raw | bits;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drop(input logic [31:0] bits);
    @(negedge clk);
    wake_raw = wake_raw & ~bits;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R1 enable", d, 32'h0);
    rd(4'h8, d); chk("R1 reason", d, 32'h0);
    chk("R1 outputs", {29'd0, sleep_req, mem_pd_req, wake_irq}, 32'h0);
  endtask

  task automatic t_enable_bytes();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF, 4'b0101);
    rd(4'h4, d); chk("R2 byte mask", d, 32'h00FF_00FF);
    wr(4'h4, 32'hC400_001A, 4'b1111);
    rd(4'h4, d); chk("R2 full write", d, 32'hC400_001A);
  endtask

  task automatic t_edge_arm();
    logic [31:0] d;
    // enable = C400001A: bits 1,3,4,26,30,31 armed; bit 0 and 2 not
    raise(32'h0000_0005);
    rd(4'h8, d); chk("R3 disabled edge ignored", d, 32'h0);
    chk("R7 irq low", {31'd0, wake_irq}, 32'h0);
    @(negedge clk);
    wake_raw = wake_raw | 32'h0000_0008;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(4'h8, d); chk("R3 not yet after two edges", d, 32'h0);
    @(negedge clk);
    rd(4'h8, d); chk("R3 set after third edge", d, 32'h0000_0008);
    chk("R7 irq high", {31'd0, wake_irq}, 32'h1);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    drop(32'h0000_000D);
    rd(4'h8, d); chk("R4 held after fall", d, 32'h0000_0008);
    raise(32'h8000_0000);
    repeat (3) @(negedge clk);
    rd(4'h8, d); chk("R4 held under level", d, 32'h8000_0008);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(4'h8, 32'h0000_0000, 4'b1111);
    rd(4'h8, d); chk("R5 zero write no effect", d, 32'h8000_0008);
    wr(4'h8, 32'h8000_0008, 4'b0111);
    rd(4'h8, d); chk("R5 masked byte kept", d, 32'h8000_0000);
    wr(4'h8, 32'h8000_0000, 4'b1000);
    rd(4'h8, d); chk("R5 ack clears", d, 32'h0);
    chk("R7 irq cleared", {31'd0, wake_irq}, 32'h0);
    drop(32'h8000_0000);
  endtask

  task automatic t_race();
    logic [31:0] d;
    raise(32'h0000_0010);
    raise(32'h0000_0002);
    drop(32'h0000_0010);
    rd(4'h8, d); chk("R6 setup", d, 32'h0000_0012);
    @(negedge clk);
    wake_raw = wake_raw | 32'h0000_0010;
    repeat (2) @(posedge clk);
    wr(4'h8, 32'h0000_0012, 4'b0001);
    rd(4'h8, d); chk("R6 edge beats ack", d, 32'h0000_0010);
    wr(4'h8, 32'h0000_0010, 4'b0001);
    rd(4'h8, d); chk("R6 later ack clears", d, 32'h0);
    drop(32'h0000_0012);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    wr(4'h0, 32'hFFFF_FFFE, 4'b1111);
    rd(4'h0, d); chk("R11 ctrl bits zero, bit15 not writable", d, 32'h0);
    wr(4'h0, 32'h0000_0001, 4'b1110);
    chk("R8 masked byte no request", {31'd0, mem_pd_req}, 32'h0);
  endtask

  task automatic t_sleep_cycle();
    logic [31:0] d;
    wr(4'h0, 32'h0000_0001, 4'b0001);
    chk("R8 pd req", {30'd0, mem_pd_req, sleep_req}, 32'h2);
    rd(4'h0, d); chk("R8 ctrl pending", d, 32'h0000_0001);
    wr(4'h0, 32'h0000_0000, 4'b1111);
    rd(4'h0, d); chk("R12 zero write no cancel", d, 32'h0000_0001);
    chk("R12 pd req held", {31'd0, mem_pd_req}, 32'h1);
    mem_pd_ack = 1'b1;
    @(negedge clk);
    chk("R9 sleep asserted", {30'd0, mem_pd_req, sleep_req}, 32'h3);
    rd(4'h0, d); chk("R9 ctrl down", d, 32'h0000_8001);
    repeat (3) @(negedge clk);
    chk("R9 stays asleep", {31'd0, sleep_req}, 32'h1);
    @(negedge clk);
    wake_raw = wake_raw | 32'h0400_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 irq on wake", {31'd0, wake_irq}, 32'h1);
    chk("R10 still asleep same cycle", {31'd0, sleep_req}, 32'h1);
    @(negedge clk);
    chk("R10 woke", {30'd0, mem_pd_req, sleep_req}, 32'h0);
    rd(4'h0, d); chk("R10 ctrl powering up", d, 32'h0000_8000);
    repeat (2) @(negedge clk);
    rd(4'h0, d); chk("R10 waits for ack low", d, 32'h0000_8000);
    mem_pd_ack = 1'b0;
    @(negedge clk);
    rd(4'h0, d); chk("R10 idle", d, 32'h0);
    rd(4'h8, d); chk("R4 reason kept after wake", d, 32'h0400_0000);
    wr(4'h8, 32'h0400_0000, 4'b1000);
    chk("R5 irq cleared after wake", {31'd0, wake_irq}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_bytes();
    t_edge_arm();
    t_hold();
    t_ack();
    t_race();
    t_ctrl_bits();
    t_sleep_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule